// File: doc/BRIEF.md
# Parameterised Floating-Point Adder/Subtractor

This block adds or subtracts two floating-point numbers held in a custom format whose exponent and fraction widths are parameters. A word is packed as `{sign, exponent, fraction}` with the sign in the top bit. The exponent bias is 2^(WEXP-1)-1. Normal numbers carry a hidden leading one. An exponent field of all ones stands for infinity, and an exponent field of zero stands for zero. The format has no NaN and no subnormal numbers. Wherever IEEE 754 would produce a NaN or an exception, this block returns a defined value and, for one case, raises an error flag.

The adder is a five-step datapath: decode, align, normalise, pack and output. A register can be inserted after each step by its own parameter, so timing can be closed one cut at a time. With every cut disabled, the block is purely combinational. A valid strobe travels alongside the data, and results are accepted on every cycle.

Top module: `fpaAdder`

## Requirements
- R1: A word is `{sign, exponent[WEXP], fraction[WMAN]}` with the sign at the MSB. An exponent field of zero is read as zero whatever the fraction or sign bits hold, and no output ever encodes negative zero: a zero result is always the all-zero word.
- R2: Finite results are rounded to the nearest representable value. Ties go to the value with an even fraction LSB. Bits shifted out during alignment still take part in the rounding decision, and a carry out of rounding bumps the exponent.
- R3: When the rounded exponent reaches all ones, the result is infinity with the sign of the true sum and a zero fraction. The error flag stays low.
- R4: An exponent field of all ones is infinity whatever its fraction bits hold. Infinity plus a finite value, and the sum of two infinities of the same sign, give that infinity with a zero fraction.
- R5: The sum of two infinities of opposite effective sign gives the all-zero word with the error flag high. In every other case the error flag is low.
- R6: A nonzero exact result whose magnitude is below half the smallest normal gives the all-zero word.
- R7: A result whose magnitude is at least half the smallest normal but below the smallest normal gives the smallest normal (exponent field 1, fraction 0) with the sign of the result.
- R8: An exact cancellation (equal magnitudes, opposite effective signs) gives the all-zero word.
- R9: `outValid` is `inValid` delayed by exactly as many cycles as there are enabled cut registers. A new operation can be issued on every cycle, and results come out in issue order.
- R10: With `subtract` high, the block returns opA minus opB, which is opA plus opB with its sign inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operands valid this cycle |
| opA | input | WEXP+WMAN+1 | First operand |
| opB | input | WEXP+WMAN+1 | Second operand |
| subtract | input | 1 | 1: opA minus opB; 0: opA plus opB |
| outValid | output | 1 | Result valid this cycle |
| result | output | WEXP+WMAN+1 | Rounded sum or difference |
| errFlag | output | 1 | High with a result from opposite infinities |

## Verification
The bench uses a narrow 6-bit exponent and 8-bit fraction, so every expected word can be worked out by hand. Three cut registers are enabled, so the valid-delay logic is tested with mixed cuts. Operand pairs are chosen so that each one reaches a single path:
- same-sign addition with a carry-out, to test the right-normalise shift;
- subtraction with a large exponent gap, to test the sticky-borrow and left-normalise path;
- additions one half-ULP apart in three variants (below, on and above a tie), to separate round-down, round-to-even and round-up;
- differences of nearby small normals that land at 0.25, 0.5 and 0.75 of the smallest normal, to separate the two underflow outcomes.

Infinities with stray fraction bits, zeros with a set sign bit and zeros with stray fraction bits show that those bits are ignored. A burst of back-to-back operations confirms ordering and throughput.

// File: rtl/fpaPkg.sv
package fpaPkg;

  // Number of optional register cuts along the datapath.
  localparam int NUM_CUTS = 5;

  // Position of each cut in the mask and in the strobe vector (the order is the datapath order).
  localparam int CUT_DECODE = 0;
  localparam int CUT_ALIGN  = 1;
  localparam int CUT_NORM   = 2;
  localparam int CUT_PACK   = 3;
  localparam int CUT_OUT    = 4;

  // Per-cut load strobes from the control to the datapath.
  typedef struct packed {
    logic [NUM_CUTS-1:0] load;
  } fpaStrobes_t;

endpackage

// File: rtl/fpaCutReg.sv
module fpaCutReg #(
  parameter int WIDTH  = 8,
  parameter bit ENABLE = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  generate
    if (ENABLE) begin : gReg
      logic [WIDTH-1:0] qReg;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)     qReg <= '0;
        else if (load) qReg <= d;
      end
      assign q = qReg;
    end else begin : gWire
      logic unusedCtl;
      assign unusedCtl = clk ^ rstN ^ load;
      assign q = d;
    end
  endgenerate

endmodule

// File: rtl/fpaControl.sv
module fpaControl
  import fpaPkg::*;
#(
  parameter logic [NUM_CUTS-1:0] CUT_MASK = '0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output fpaStrobes_t strobes,
  output logic        outValid
);

  // vChain[i] is the valid bit entering cut i; vChain[NUM_CUTS] leaves the last one.
  logic [NUM_CUTS:0] vChain;
  logic              unusedRef;

  assign unusedRef = clk ^ rstN;
  assign vChain[0] = inValid;

  generate
    for (genvar i = 0; i < NUM_CUTS; i++) begin : gCut
      if (CUT_MASK[i]) begin : gOn
        logic vReg;
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) vReg <= 1'b0;
          else       vReg <= vChain[i];
        end
        assign vChain[i+1] = vReg;
      end else begin : gOff
        assign vChain[i+1] = vChain[i];
      end
    end
  endgenerate

  assign strobes.load = vChain[NUM_CUTS-1:0];
  assign outValid     = vChain[NUM_CUTS];

endmodule

// File: rtl/fpaDatapath.sv
module fpaDatapath
  import fpaPkg::*;
#(
  parameter int                  WEXP     = 6,
  parameter int                  WMAN     = 18,
  parameter logic [NUM_CUTS-1:0] CUT_MASK = '0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  fpaStrobes_t          strobes,
  input  logic [WEXP+WMAN:0]   opA,
  input  logic [WEXP+WMAN:0]   opB,
  input  logic                 subtract,
  output logic [WEXP+WMAN:0]   result,
  output logic                 errFlag
);

  localparam int WW  = WEXP + WMAN + 1;     // word width
  localparam int WM1 = WMAN + 1;            // mantissa with hidden one
  localparam int WX  = WM1 + 3;             // plus guard, round, sticky
  localparam int WS  = WX + 1;              // plus carry
  localparam int LZW = $clog2(WX + 1);
  localparam int WE  = WEXP + LZW + 2;      // signed working exponent
  localparam logic [WEXP-1:0]      EXP_INF = '1;
  localparam logic signed [WE-1:0] E_ONE   = 1;
  localparam logic signed [WE-1:0] E_INF   = $signed({{(WE-WEXP){1'b0}}, EXP_INF});

  typedef struct packed {
    logic            sign;
    logic [WEXP-1:0] expL;
    logic [WM1-1:0]  mantL;
    logic [WM1-1:0]  mantS;
    logic [WEXP-1:0] diff;
    logic            effSub;
    logic            special;
    logic [WW-1:0]   specWord;
    logic            specErr;
  } decStage_t;

  typedef struct packed {
    logic            sign;
    logic [WEXP-1:0] expL;
    logic [WS-1:0]   sum;
    logic            special;
    logic [WW-1:0]   specWord;
    logic            specErr;
  } alnStage_t;

  typedef struct packed {
    logic                 sign;
    logic signed [WE-1:0] expN;
    logic [WX-1:0]        mant;
    logic                 isZero;
    logic                 special;
    logic [WW-1:0]        specWord;
    logic                 specErr;
  } nrmStage_t;

  typedef struct packed {
    logic [WW-1:0] word;
    logic          err;
  } packStage_t;

  decStage_t  decD, decQ;
  alnStage_t  alnD, alnQ;
  nrmStage_t  nrmD, nrmQ;
  packStage_t pckD, pckQ, outQ;

  // ---------------- decode ----------------
  logic            aSign, bSign, aZero, bZero, aInf, bInf, swap;
  logic [WEXP-1:0] aExp, bExp, expS;
  logic [WMAN-1:0] aFrac, bFrac;
  logic [WM1-1:0]  aMant, bMant;

  always_comb begin
    aSign = opA[WW-1];
    bSign = opB[WW-1] ^ subtract;
    aExp  = opA[WW-2 -: WEXP];
    bExp  = opB[WW-2 -: WEXP];
    aFrac = opA[WMAN-1:0];
    bFrac = opB[WMAN-1:0];
    aZero = (aExp == '0);
    bZero = (bExp == '0);
    aInf  = (aExp == EXP_INF);
    bInf  = (bExp == EXP_INF);
    aMant = aZero ? '0 : {1'b1, aFrac};
    bMant = bZero ? '0 : {1'b1, bFrac};
    swap  = {bExp, bFrac} > {aExp, aFrac};

    decD.sign   = swap ? bSign : aSign;
    decD.expL   = swap ? bExp  : aExp;
    expS        = swap ? aExp  : bExp;
    decD.mantL  = swap ? bMant : aMant;
    decD.mantS  = swap ? aMant : bMant;
    decD.diff   = decD.expL - expS;
    decD.effSub = aSign ^ bSign;

    decD.special = aInf | bInf;
    decD.specErr = aInf & bInf & (aSign != bSign);
    if (decD.specErr)  decD.specWord = '0;
    else if (aInf)     decD.specWord = {aSign, EXP_INF, {WMAN{1'b0}}};
    else               decD.specWord = {bSign, EXP_INF, {WMAN{1'b0}}};
  end

  fpaCutReg #(.WIDTH($bits(decStage_t)), .ENABLE(CUT_MASK[CUT_DECODE])) u_cutDec (
    .clk(clk), .rstN(rstN), .load(strobes.load[CUT_DECODE]), .d(decD), .q(decQ));

  // ---------------- align and add ----------------
  logic [WX-1:0] extS, extL, shS;

  always_comb begin
    extS = {decQ.mantS, 3'b000};
    extL = {decQ.mantL, 3'b000};
    if (int'(decQ.diff) >= WX) begin
      shS    = '0;
      shS[0] = |decQ.mantS;
    end else begin
      shS    = extS >> decQ.diff;
      shS[0] = shS[0] | (|(extS & ~({WX{1'b1}} << decQ.diff)));
    end
    alnD.sum      = decQ.effSub ? ({1'b0, extL} - {1'b0, shS})
                                : ({1'b0, extL} + {1'b0, shS});
    alnD.sign     = decQ.sign;
    alnD.expL     = decQ.expL;
    alnD.special  = decQ.special;
    alnD.specWord = decQ.specWord;
    alnD.specErr  = decQ.specErr;
  end

  fpaCutReg #(.WIDTH($bits(alnStage_t)), .ENABLE(CUT_MASK[CUT_ALIGN])) u_cutAln (
    .clk(clk), .rstN(rstN), .load(strobes.load[CUT_ALIGN]), .d(alnD), .q(alnQ));

  // ---------------- normalise ----------------
  logic [LZW-1:0]       lz;
  logic                 lzFound;
  logic signed [WE-1:0] eL;

  always_comb begin
    lz      = '0;
    lzFound = 1'b0;
    for (int i = WX - 1; i >= 0; i--) begin
      if (!lzFound && alnQ.sum[i]) begin
        lz      = LZW'(WX - 1 - i);
        lzFound = 1'b1;
      end
    end
    eL = $signed({{(WE-WEXP){1'b0}}, alnQ.expL});
    if (alnQ.sum[WS-1]) begin
      nrmD.mant = {alnQ.sum[WS-1:2], alnQ.sum[1] | alnQ.sum[0]};
      nrmD.expN = eL + E_ONE;
    end else begin
      nrmD.mant = alnQ.sum[WX-1:0] << lz;
      nrmD.expN = eL - $signed({{(WE-LZW){1'b0}}, lz});
    end
    nrmD.isZero   = (alnQ.sum == '0);
    nrmD.sign     = alnQ.sign;
    nrmD.special  = alnQ.special;
    nrmD.specWord = alnQ.specWord;
    nrmD.specErr  = alnQ.specErr;
  end

  fpaCutReg #(.WIDTH($bits(nrmStage_t)), .ENABLE(CUT_MASK[CUT_NORM])) u_cutNrm (
    .clk(clk), .rstN(rstN), .load(strobes.load[CUT_NORM]), .d(nrmD), .q(nrmQ));

  // ---------------- round and pack ----------------
  logic                 rUp;
  logic [WM1:0]         mRnd;
  logic signed [WE-1:0] eR;

  always_comb begin
    rUp  = nrmQ.mant[2] & (nrmQ.mant[1] | nrmQ.mant[0] | nrmQ.mant[3]);
    mRnd = {1'b0, nrmQ.mant[WX-1:3]} + {{WM1{1'b0}}, rUp};
    eR   = mRnd[WM1] ? nrmQ.expN + E_ONE : nrmQ.expN;
    pckD.err = 1'b0;
    if (nrmQ.special) begin
      pckD.word = nrmQ.specWord;
      pckD.err  = nrmQ.specErr;
    end else if (nrmQ.isZero || nrmQ.expN < 0) begin
      pckD.word = '0;
    end else if (nrmQ.expN == 0) begin
      pckD.word = {nrmQ.sign, {{(WEXP-1){1'b0}}, 1'b1}, {WMAN{1'b0}}};
    end else if (eR >= E_INF) begin
      pckD.word = {nrmQ.sign, EXP_INF, {WMAN{1'b0}}};
    end else begin
      pckD.word = {nrmQ.sign, eR[WEXP-1:0], mRnd[WMAN-1:0]};
    end
  end

  fpaCutReg #(.WIDTH($bits(packStage_t)), .ENABLE(CUT_MASK[CUT_PACK])) u_cutPck (
    .clk(clk), .rstN(rstN), .load(strobes.load[CUT_PACK]), .d(pckD), .q(pckQ));

  fpaCutReg #(.WIDTH($bits(packStage_t)), .ENABLE(CUT_MASK[CUT_OUT])) u_cutOut (
    .clk(clk), .rstN(rstN), .load(strobes.load[CUT_OUT]), .d(pckQ), .q(outQ));

  assign result  = outQ.word;
  assign errFlag = outQ.err;

endmodule

// File: rtl/fpaAdder.sv
module fpaAdder
  import fpaPkg::*;
#(
  parameter int WEXP       = 6,
  parameter int WMAN       = 18,
  parameter bit STG_DECODE = 1'b0,
  parameter bit STG_ALIGN  = 1'b0,
  parameter bit STG_NORM   = 1'b0,
  parameter bit STG_PACK   = 1'b0,
  parameter bit STG_OUT    = 1'b0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [WEXP+WMAN:0] opA,
  input  logic [WEXP+WMAN:0] opB,
  input  logic               subtract,
  output logic               outValid,
  output logic [WEXP+WMAN:0] result,
  output logic               errFlag
);

  localparam logic [NUM_CUTS-1:0] CUT_MASK = {STG_OUT, STG_PACK, STG_NORM, STG_ALIGN, STG_DECODE};

  fpaStrobes_t strobes;

  fpaControl #(.CUT_MASK(CUT_MASK)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .strobes(strobes), .outValid(outValid));

  fpaDatapath #(.WEXP(WEXP), .WMAN(WMAN), .CUT_MASK(CUT_MASK)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .opA(opA), .opB(opB),
    .subtract(subtract), .result(result), .errFlag(errFlag));

endmodule

// File: rtl/fpaAdderChk.sv
module fpaAdderChk #(
  parameter int WEXP = 6,
  parameter int WMAN = 18,
  parameter int LAT  = 0
) (
  input logic               clk,
  input logic               rstN,
  input logic               inValid,
  input logic               outValid,
  input logic [WEXP+WMAN:0] result,
  input logic               errFlag
);

  localparam logic [WEXP-1:0] EXP_INF = '1;

  logic            rSign;
  logic [WEXP-1:0] rExp;
  logic [WMAN-1:0] rFrac;
  logic            expV;

  assign rSign = result[WEXP+WMAN];
  assign rExp  = result[WEXP+WMAN-1 -: WEXP];
  assign rFrac = result[WMAN-1:0];

  // Independent model of the valid delay.
  generate
    if (LAT == 0) begin : gComb
      assign expV = inValid;
    end else begin : gSeq
      logic [LAT-1:0] vHist;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) vHist <= '0;
        else       vHist <= (vHist << 1) | LAT'(inValid);
      end
      assign expV = vHist[LAT-1];
    end
  endgenerate

  assert_valid_delay_R9: assert property (@(posedge clk) disable iff (!rstN)
    outValid == expV);

  assert_no_neg_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !(rSign && rExp == '0));

  assert_zero_canonical_R1: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && rExp == '0) |-> rFrac == '0);

  assert_inf_canonical_R4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && rExp == EXP_INF) |-> rFrac == '0);

  assert_err_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && errFlag) |-> result == '0);

endmodule

bind fpaAdder fpaAdderChk #(
  .WEXP(WEXP),
  .WMAN(WMAN),
  .LAT(int'(STG_DECODE) + int'(STG_ALIGN) + int'(STG_NORM) + int'(STG_PACK) + int'(STG_OUT))
) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .outValid(outValid),
  .result(result), .errFlag(errFlag)
);

// File: tb/fpaAdder_tb.sv
`timescale 1ns/1ps
module fpaAdder_tb;

  localparam int WEXP = 6;
  localparam int WMAN = 8;
  localparam int WW   = WEXP + WMAN + 1;
  localparam int LAT  = 3;   // decode, normalise and output cuts enabled

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic [WW-1:0] opA = '0;
  logic [WW-1:0] opB = '0;
  logic          subtract = 1'b0;
  logic          outValid;
  logic [WW-1:0] result;
  logic          errFlag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fpaAdder #(
    .WEXP(WEXP), .WMAN(WMAN),
    .STG_DECODE(1'b1), .STG_ALIGN(1'b0), .STG_NORM(1'b1), .STG_PACK(1'b0), .STG_OUT(1'b1)
  ) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .subtract(subtract), .outValid(outValid), .result(result), .errFlag(errFlag)
  );

  function automatic logic [WW-1:0] mk(input logic s, input int e, input int f);
    return {s, WEXP'(e), WMAN'(f)};
  endfunction

  task automatic check(input string req, input string what, input logic [WW-1:0] act,
                       input logic [WW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic runOp(input string req, input logic [WW-1:0] a, input logic [WW-1:0] b,
                       input logic sub, input logic [WW-1:0] expW, input logic expE);
    @(negedge clk);
    opA = a; opB = b; subtract = sub; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    repeat (LAT - 1) @(negedge clk);
    check(req, "outValid", WW'(outValid), WW'(1));
    check(req, "result", result, expW);
    check(req, "errFlag", WW'(errFlag), WW'(expE));
  endtask

  task automatic testReset();
    check("R9", "reset outValid", WW'(outValid), '0);
    check("R1", "reset result", result, '0);
  endtask

  task automatic testBasic();
    runOp("R2", mk(0,31,0), mk(0,31,0), 0, mk(0,32,0), 0);         // 1+1
    runOp("R2", mk(0,31,8'h80), mk(0,31,8'h80), 0, mk(0,32,8'h80), 0); // 1.5+1.5
    runOp("R10", mk(0,31,8'h80), mk(0,30,0), 1, mk(0,31,0), 0);    // 1.5-0.5
    runOp("R10", mk(0,31,0), mk(0,31,8'h80), 1, mk(1,30,0), 0);    // 1-1.5
    runOp("R10", mk(0,31,0), mk(1,31,8'h80), 1, mk(0,32,8'h40), 0);// 1-(-1.5)
  endtask

  task automatic testRounding();
    runOp("R2", mk(0,31,0), mk(0,22,0), 0, mk(0,31,0), 0);         // tie, even stays
    runOp("R2", mk(0,31,0), mk(0,22,8'h80), 0, mk(0,31,1), 0);     // above half
    runOp("R2", mk(0,31,1), mk(0,22,0), 0, mk(0,31,2), 0);         // tie, odd goes up
    runOp("R2", mk(0,31,8'hFF), mk(0,22,0), 0, mk(0,32,0), 0);     // rounding carry
    runOp("R2", mk(0,31,0), mk(0,1,0), 0, mk(0,31,0), 0);          // sticky only
    runOp("R2", mk(0,31,0), mk(0,1,0), 1, mk(0,31,0), 0);          // sticky borrow
  endtask

  task automatic testCancel();
    runOp("R8", mk(0,31,0), mk(1,31,0), 0, '0, 0);
    runOp("R8", mk(1,40,8'h33), mk(1,40,8'h33), 1, '0, 0);
  endtask

  task automatic testZeros();
    runOp("R1", mk(1,0,8'h55), mk(0,31,0), 0, mk(0,31,0), 0);
    runOp("R1", mk(1,0,0), mk(1,0,0), 0, '0, 0);
    runOp("R1", mk(0,0,8'h7F), mk(1,30,0), 0, mk(1,30,0), 0);
  endtask

  task automatic testOverflow();
    runOp("R3", mk(0,62,8'hFF), mk(0,62,8'hFF), 0, mk(0,63,0), 0);
    runOp("R3", mk(1,62,8'hFF), mk(1,62,8'hFF), 0, mk(1,63,0), 0);
    runOp("R3", mk(0,62,8'hFF), mk(0,53,0), 0, mk(0,63,0), 0);     // via rounding
  endtask

  task automatic testInfinity();
    runOp("R4", mk(0,63,0), mk(0,31,0), 0, mk(0,63,0), 0);
    runOp("R4", mk(0,63,8'h3C), mk(1,31,0), 0, mk(0,63,0), 0);
    runOp("R4", mk(1,63,0), mk(0,63,0), 1, mk(1,63,0), 0);
    runOp("R4", mk(0,31,0), mk(0,63,8'h01), 1, mk(1,63,0), 0);
    runOp("R5", mk(0,63,0), mk(1,63,0), 0, '0, 1);
    runOp("R5", mk(0,63,8'h11), mk(0,63,0), 1, '0, 1);
  endtask

  task automatic testUnderflow();
    runOp("R6", mk(0,1,1), mk(0,1,0), 1, '0, 0);
    runOp("R6", mk(0,2,8'h20), mk(0,2,0), 1, '0, 0);               // 0.25 min
    runOp("R7", mk(0,2,8'h40), mk(0,2,0), 1, mk(0,1,0), 0);        // 0.5 min
    runOp("R7", mk(0,2,0), mk(0,2,8'h40), 1, mk(1,1,0), 0);        // -0.5 min
    runOp("R7", mk(0,2,8'h60), mk(0,2,0), 1, mk(0,1,0), 0);        // 0.75 min
  endtask

  task automatic testLatency();
    @(negedge clk);
    opA = mk(0,31,0); opB = mk(0,31,0); subtract = 1'b0; inValid = 1'b1;
    for (int c = 1; c <= LAT + 1; c++) begin
      @(negedge clk);
      inValid = 1'b0;
      check("R9", $sformatf("outValid at cycle %0d", c), WW'(outValid), WW'(c == LAT));
    end
  endtask

  task automatic testBurst();
    logic [WW-1:0] aV [3];
    logic [WW-1:0] bV [3];
    logic [WW-1:0] eV [3];
    aV[0] = mk(0,31,0);     bV[0] = mk(0,31,0);     eV[0] = mk(0,32,0);
    aV[1] = mk(0,31,8'h80); bV[1] = mk(0,30,0);     eV[1] = mk(0,32,0);
    aV[2] = mk(1,33,0);     bV[2] = mk(1,33,0);     eV[2] = mk(1,34,0);
    for (int c = 0; c < LAT + 3; c++) begin
      @(negedge clk);
      if (c >= LAT) begin
        check("R9", "burst outValid", WW'(outValid), WW'(1));
        check("R9", $sformatf("burst result %0d", c - LAT), result, eV[c-LAT]);
      end
      if (c < 3) begin
        opA = aV[c]; opB = bV[c]; subtract = 1'b0; inValid = 1'b1;
      end else begin
        inValid = 1'b0;
      end
    end
    @(negedge clk);
    check("R9", "burst end outValid", WW'(outValid), '0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R9 watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testBasic();
    testRounding();
    testCancel();
    testZeros();
    testOverflow();
    testInfinity();
    testUnderflow();
    testLatency();
    testBurst();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule